// File: doc/BRIEF.md
# Exponential-Ratio Clock Enable Divider

This block slows a fast peripheral clock down for a bus controller without creating a second clock domain. A 4-bit code selects the division ratio. Code zero passes the clock straight through. Any nonzero code n divides by 2^(n-1)+1, so the available ratios are odd numbers, apart from the divide-by-2 at code 1. The output is a one-cycle clock-enable pulse in the input clock domain. Logic downstream advances its state only on cycles where the pulse is high.

Software loads the code through a 32-bit write port and reads it back on a 32-bit read port. Only the low four bits are stored. The upper bits read as zero, and anything written to them is dropped. Every write restarts the internal countdown, so a new ratio takes effect from a known instant. A synchronous reset restores the divide-by-2 code and restarts the count in the same way.

Top module: `clkRatioDivider`

## Requirements
- R1: `rdData[3:0]` returns the stored code in the cycle after the write edge, and `rdData[31:4]` always reads zero.
- R2: After reset the stored code is 1 (divide-by-2). The first `clkEn` pulse is visible in the second cycle after the last clock edge that samples `rst` high.
- R3: With code 0, `clkEn` is high on every cycle.
- R4: With a nonzero code n, `clkEn` pulses are one cycle wide and repeat every 2^(n-1)+1 cycles, with 2^(n-1) idle cycles between them (code 1: 2, code 2: 3, code 3: 5, code 4: 9, code 5: 17).
- R5: Code 15 gives a spacing of 16385 cycles between pulses.
- R6: A write restarts the count. If the write is sampled at edge W, the first pulse with the new ratio r is visible in the cycle that follows edge W+r-1. No pulse from the old ratio appears in between.
- R7: Bits 31:4 of a write have no effect on the stored code or on the pulse spacing.
- R8: Reset overrides an earlier write and restores code 1 and the divide-by-2 spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for the divider code |
| wrData | input | 32 | Write data; bits 3:0 carry the code |
| rdData | output | 32 | Readback; code in bits 3:0, zero above |
| clkEn | output | 1 | One-cycle enable pulse at the divided rate |

## Verification
The assertions assume that `wrEn` and `wrData` change only between clock edges and that `rst` is held high on the first clock edge, so the count starts from a defined reload value. The pulse-width check also assumes that no write arrives in the cycle right after a pulse. The stimulus drives every input half a period away from the rising edge and asserts reset before any write. Writes are spaced far enough apart that each ratio produces whole pulse periods. The one exception is the deliberate restart case, where a write lands in the middle of a long period.

// File: rtl/clkRatioPkg.sv
package clkRatioPkg;
  typedef struct packed {
    logic selReset;
    logic loadCode;
    logic reloadCnt;
    logic decCnt;
  } cntStrobes_t;
endpackage

// File: rtl/clkRatioCtrl.sv
module clkRatioCtrl
  import clkRatioPkg::*;
(
  input  logic        rst,
  input  logic        wrEn,
  input  logic        cntZero,
  output cntStrobes_t strb
);
  always_comb begin
    strb.selReset  = rst;
    strb.loadCode  = rst | wrEn;
    strb.reloadCnt = rst | wrEn | cntZero;
    strb.decCnt    = ~(rst | wrEn | cntZero);
  end
endmodule

// File: rtl/clkRatioPath.sv
module clkRatioPath
  import clkRatioPkg::*;
#(
  parameter int CODE_W = 4,
  parameter int REG_W = 32,
  parameter logic [CODE_W-1:0] RESET_CODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  cntStrobes_t       strb,
  input  logic [CODE_W-1:0] wrCode,
  output logic [REG_W-1:0]  rdData,
  output logic              cntZero,
  output logic              clkEn
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] nextCode;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  reloadVal;
  logic [CNT_W-1:0]  limitVal;

  function automatic logic [CNT_W-1:0] ratioMinusOne(input logic [CODE_W-1:0] c);
    logic [CNT_W-1:0] v;
    v = '0;
    if (c != '0) v[c - 1'b1] = 1'b1;
    return v;
  endfunction

  always_comb begin
    if (strb.selReset)      nextCode = RESET_CODE;
    else if (strb.loadCode) nextCode = wrCode;
    else                    nextCode = code;
  end

  assign reloadVal = ratioMinusOne(nextCode);
  assign limitVal  = ratioMinusOne(code);

  always_ff @(posedge clk) begin
    if (strb.loadCode) code <= nextCode;
  end

  always_ff @(posedge clk) begin
    if (strb.reloadCnt)   count <= reloadVal;
    else if (strb.decCnt) count <= count - 1'b1;
  end

  assign cntZero = (count == '0);
  assign clkEn   = cntZero;
  assign rdData  = {{(REG_W-CODE_W){1'b0}}, code};

  // R2 / R8: reset restores divide-by-2 code and its reload
  assert_reset_restore_R8: assert property (@(posedge clk)
    rst |=> (code == RESET_CODE) && (count == ratioMinusOne(RESET_CODE)))
    else $error("reset did not restore code");

  // R1: written code appears on readback
  assert_write_load_R1: assert property (@(posedge clk) disable iff (rst)
    strb.loadCode |=> rdData[CODE_W-1:0] == $past(wrCode))
    else $error("write not stored");

  // R4: counter never exceeds the period of the current code
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    count <= limitVal)
    else $error("count above reload");

  // R4: pulse is one cycle wide for ratios above one
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    (clkEn && code != '0 && !strb.loadCode) |=> !clkEn)
    else $error("pulse wider than one cycle");

  // R4: steady countdown between pulses
  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!strb.loadCode && !cntZero) |=> count == $past(count) - 1'b1)
    else $error("count did not step");

  // R3: code zero keeps the enable high
  assert_pass_through_R3: assert property (@(posedge clk) disable iff (rst)
    (code == '0 && !strb.loadCode) |=> clkEn)
    else $error("pass-through lost");
endmodule

// File: rtl/clkRatioDivider.sv
module clkRatioDivider
  import clkRatioPkg::*;
#(
  parameter int CODE_W = 4,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             clkEn
);
  cntStrobes_t strb;
  logic        cntZero;

  clkRatioCtrl uCtrl (
    .rst     (rst),
    .wrEn    (wrEn),
    .cntZero (cntZero),
    .strb    (strb)
  );

  clkRatioPath #(
    .CODE_W     (CODE_W),
    .REG_W      (REG_W),
    .RESET_CODE (CODE_W'(1))
  ) uPath (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .wrCode  (wrData[CODE_W-1:0]),
    .rdData  (rdData),
    .cntZero (cntZero),
    .clkEn   (clkEn)
  );
endmodule

// File: tb/sim_clkRatioDivider.sv
`timescale 1ns/1ps
module sim_clkRatioDivider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        clkEn;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit active = 1'b0;
  bit done = 1'b0;
  string curReq = "R2";
  int expQ[$];

  clkRatioDivider u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .clkEn(clkEn)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ratioOf(input int c);
    return (c == 0) ? 1 : (1 << (c - 1)) + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compare observed pulses against the expected queue
  always @(negedge clk) begin
    if (active) begin
      if (clkEn) begin
        if (expQ.size() == 0) check(1'b0, curReq, cyc, -1);
        else begin
          check(expQ[0] == cyc, curReq, cyc, expQ[0]);
          if (expQ[0] <= cyc) void'(expQ.pop_front());
        end
      end else if (expQ.size() != 0 && expQ[0] <= cyc) begin
        check(1'b0, curReq, cyc, expQ[0]);
        void'(expQ.pop_front());
      end
      if (expQ.size() == 0) active = 1'b0;
    end
  end

  task automatic pushPulses(input int base, input int r, input int n);
    for (int k = 1; k <= n; k++) expQ.push_back(base + k * r - 1);
    active = 1'b1;
  endtask

  task automatic doWrite(input logic [31:0] d, output int w);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(posedge clk); #1;
    w = cyc;
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic waitDrain();
    while (active) @(negedge clk);
  endtask

  task automatic runCode(input int c, input int n, input string req);
    int w;
    curReq = req;
    doWrite(32'(c), w);
    pushPulses(w, ratioOf(c), n);
    @(negedge clk);
    check(rdData == 32'(c), "R1", int'(rdData), c);
    waitDrain();
  endtask

  task automatic doReset(input int n);
    int rEdge;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rEdge = cyc;
    rst = 1'b0;
    curReq = "R2";
    pushPulses(rEdge, 2, n);
    @(negedge clk);
    check(rdData == 32'd1, "R2", int'(rdData), 1);
    waitDrain();
  endtask

  initial begin
    int w;
    doReset(3);
    // every code, spacing from the reference ratio
    for (int c = 0; c < 16; c++) begin
      if (c == 0)       runCode(c, 6, "R3");
      else if (c == 15) runCode(c, 2, "R5");
      else              runCode(c, (c <= 10) ? 3 : 2, "R4");
    end
    // R7: upper write bits ignored
    runCode(2, 1, "R7");
    curReq = "R7";
    doWrite(32'hFFFF_FFF3, w);
    pushPulses(w, 5, 3);
    @(negedge clk);
    check(rdData == 32'd3, "R7", int'(rdData), 3);
    waitDrain();
    // R6: restart mid-period with a shorter ratio
    curReq = "R6";
    doWrite(32'd5, w);
    repeat (6) @(negedge clk);
    doWrite(32'd3, w);
    pushPulses(w, 5, 3);
    waitDrain();
    // R6: restart into pass-through
    doWrite(32'd8, w);
    repeat (3) @(negedge clk);
    doWrite(32'd0, w);
    pushPulses(w, 1, 4);
    waitDrain();
    // R8: reset after a write restores divide-by-2
    curReq = "R8";
    doWrite(32'd7, w);
    repeat (4) @(negedge clk);
    doReset(3);
    check(rdData[31:4] == 28'd0, "R1", int'(rdData[31:4]), 0);
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 190000) @(negedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule